// File: doc/BRIEF.md
# Multiplierless Quarter-Wave Sine Synthesizer

This block is a numerically controlled sine carrier generator. A wide phase accumulator advances by a programmable increment on every enabled clock. A 12-bit phase is taken from its upper bits, and a caller-supplied offset is added to it. That phase is then turned into a signed amplitude by a converter that uses neither a lookup memory nor a multiplier.

The converter uses quarter-wave symmetry. The two top phase bits name the quadrant. Odd quadrants are folded by inverting the in-quadrant bits. The folded quarter is cut into eight straight segments, and each segment's magnitude is a constant start value plus two right-shifted copies of the position inside the segment. A second converter, fed the same phase advanced by a quarter circle, gives a cosine sample.

The block is used as the carrier source in a phase-shift-keyed modulator. Changing the increment while the block runs hops the frequency. Changing the offset turns the carrier's phase. The output frequency is f_clk × increment / 2^24.

Top module: `qws_synth`

## Requirements
- R1: While `rst_i` is high at a rising edge, the accumulator and both outputs are cleared to zero. The first samples after reset is released are therefore 0.
- R2: At each rising edge with `en_i` high, the accumulator becomes (accumulator + `inc_i`) mod 2^24. With `en_i` low, the accumulator keeps its value.
- R3: The block has two register stages. At edge k, the phase register loads accumulator bits [23:12] as they stood before edge k, plus `ofs_i`. At edge k+1, the outputs load the converted amplitude of that phase.
- R4: The phase's bits [11:10] give the quadrant. When bit 10 is 1, the low 10 bits are ones-complemented before conversion. When bit 10 is 0, they are used as they are.
- R5: Of the folded 10-bit value, bits [9:7] select segment s and bits [6:0] form the sub-angle u. The magnitude is base[s] + (u >> a[s]) + (u >> b[s]), with the shifts truncating. For s = 0..7: base = 0, 200, 391, 568, 723, 851, 945, 1003; a = 0, 0, 0, 0, 1, 1, 2, 3; b = 1, 1, 2, 3, 1, 2, 3, 5.
- R6: When phase bit 11 is 1, the sample is the two's-complement negative of the magnitude. Otherwise the sample is the magnitude itself.
- R7: `cos_o` is the same conversion applied to the registered phase plus 1024, taken mod 4096.
- R8: The offset is added to the accumulator's phase mod 4096, so offsets near 4095 wrap correctly.
- R9: A new `inc_i` value is used at the very next rising edge, with no extra delay stage.
- R10: For any phase p, the sine sample differs from 1023·sin(2πp/4096) by no more than 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Accumulator advance enable |
| inc_i | input | 24 | Phase increment per clock (frequency word) |
| ofs_i | input | 12 | Phase offset added to the 12-bit phase |
| sin_o | output | 12 | Sine sample, two's complement |
| cos_o | output | 12 | Cosine sample, two's complement |

## Verification
Several events can land on the same clock edge: a frequency hop, an offset change, and the accumulator wrapping past 2^24. The bench makes them coincide by changing `inc_i` and `ofs_i` together on the same edge, at irregular points of a fast sweep. It uses increments close to 2^24, so that wraps happen on nearly every cycle. A behavioural model steps forward one clock at a time from the stated formulas. The model is compared with both outputs on every cycle, so any skew between the accumulator path and the offset path shows up as a mismatch.

// File: rtl/qws_pkg.sv
package qws_pkg;

    // Number of straight segments per quarter wave, as a bit count
    localparam int SEG_W   = 3;
    // Sub-angle width the shift table is tuned for
    localparam int SUB_REF = 7;
    // Unsigned magnitude width
    localparam int MAG_W   = 10;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [MAG_W-1:0] mag_t;

    // Magnitude at each segment start: round(1023 * sin(s*pi/16))
    function automatic mag_t seg_base(input seg_t s);
        case (s)
            3'd0:    return mag_t'(0);
            3'd1:    return mag_t'(200);
            3'd2:    return mag_t'(391);
            3'd3:    return mag_t'(568);
            3'd4:    return mag_t'(723);
            3'd5:    return mag_t'(851);
            3'd6:    return mag_t'(945);
            default: return mag_t'(1003);
        endcase
    endfunction

    // First slope term shift
    function automatic int unsigned shift_a(input seg_t s);
        case (s)
            3'd0, 3'd1, 3'd2, 3'd3: return 0;
            3'd4, 3'd5:             return 1;
            3'd6:                   return 2;
            default:                return 3;
        endcase
    endfunction

    // Second slope term shift
    function automatic int unsigned shift_b(input seg_t s);
        case (s)
            3'd0, 3'd1, 3'd4: return 1;
            3'd2, 3'd5:       return 2;
            3'd3, 3'd6:       return 3;
            default:          return 5;
        endcase
    endfunction

endpackage

// File: rtl/qws_accum.sv
module qws_accum #(
    parameter int ACC_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] acc_q;

    always_comb begin
        acc_d = acc_q;
        if (en_i) begin
            acc_d = acc_q + inc_i;
        end
        if (rst_i) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/qws_conv.sv
module qws_conv #(
    parameter int PH_W  = 12,
    parameter int OUT_W = 12
) (
    input  logic [PH_W-1:0]         ph_i,
    output logic signed [OUT_W-1:0] amp_o
);
    import qws_pkg::*;

    localparam int Q_W   = PH_W - 2;
    localparam int SUB_W = Q_W - SEG_W;
    localparam int NORM  = SUB_W - SUB_REF;

    logic [1:0]       quad;
    logic [Q_W-1:0]   fold;
    seg_t             seg;
    logic [SUB_W-1:0] sub;
    mag_t             term_a;
    mag_t             term_b;
    mag_t             mag;

    always_comb begin
        quad   = ph_i[PH_W-1 -: 2];
        // odd quadrants run the quarter wave backwards
        fold   = quad[0] ? ~ph_i[Q_W-1:0] : ph_i[Q_W-1:0];
        seg    = fold[Q_W-1 -: SEG_W];
        sub    = fold[SUB_W-1:0];
        term_a = mag_t'(sub >> (shift_a(seg) + NORM));
        term_b = mag_t'(sub >> (shift_b(seg) + NORM));
        mag    = seg_base(seg) + term_a + term_b;
        if (quad[1]) begin
            amp_o = -$signed({{(OUT_W-MAG_W){1'b0}}, mag});
        end else begin
            amp_o = $signed({{(OUT_W-MAG_W){1'b0}}, mag});
        end
    end

endmodule

// File: rtl/qws_synth.sv
module qws_synth #(
    parameter int ACC_W    = 24,
    parameter int PH_W     = 12,
    parameter int OUT_W    = 12,
    parameter bit WITH_COS = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [ACC_W-1:0] inc_i,
    input  logic [PH_W-1:0]  ofs_i,
    output logic [OUT_W-1:0] sin_o,
    output logic [OUT_W-1:0] cos_o
);

    localparam int QUARTER = 1 << (PH_W - 2);
    localparam int NCH     = 2;

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [OUT_W-1:0] sin;
        logic [OUT_W-1:0] cos;
    } stage_t;

    stage_t           st_d;
    stage_t           st_q;
    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  ph_q;
    logic signed [OUT_W-1:0] amp [NCH];

    qws_accum #(.ACC_W(ACC_W)) u_acc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .inc_i (inc_i),
        .acc_o (acc_q)
    );

    assign ph_q = st_q.ph;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        if (ch == 0 || WITH_COS) begin : g_conv
            logic [PH_W-1:0] ph_ch;
            assign ph_ch = ph_q + PH_W'(ch * QUARTER);
            qws_conv #(.PH_W(PH_W), .OUT_W(OUT_W)) u_conv (
                .ph_i  (ph_ch),
                .amp_o (amp[ch])
            );
        end else begin : g_off
            assign amp[ch] = '0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.ph  = acc_q[ACC_W-1 -: PH_W] + ofs_i;
        st_d.sin = amp[0];
        st_d.cos = amp[1];
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sin_o = st_q.sin;
    assign cos_o = st_q.cos;

endmodule

// File: rtl/qws_synth_chk.sv
module qws_synth_chk #(
    parameter int ACC_W = 24,
    parameter int PH_W  = 12,
    parameter int OUT_W = 12
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic [ACC_W-1:0] inc_i,
    input logic [ACC_W-1:0] acc_q,
    input logic [PH_W-1:0]  ph_q,
    input logic [OUT_W-1:0] sin_o,
    input logic [OUT_W-1:0] cos_o
);

    localparam int LIM = (1 << qws_pkg::MAG_W) - 1;

    // R1: a reset edge leaves accumulator and outputs at zero
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (acc_q == '0 && sin_o == '0 && cos_o == '0));

    // R2: enabled edge adds the increment, modulo the accumulator width
    p_acc_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> acc_q == ACC_W'($past(acc_q) + $past(inc_i)));

    // R2: disabled edge holds the accumulator
    p_acc_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(acc_q));

    // R6: phase in the lower half circle gives a non-positive sample
    p_neg_half_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ph_q[PH_W-1] |=> $signed(sin_o) <= 0);

    // R6: phase in the upper half circle gives a non-negative sample
    p_pos_half_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !ph_q[PH_W-1] |=> $signed(sin_o) >= 0);

    // R5: magnitudes stay inside the unsigned magnitude range
    p_sin_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($signed(sin_o) <= LIM) && ($signed(sin_o) >= -LIM));

    // R7: cosine path stays inside the same range
    p_cos_range_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($signed(cos_o) <= LIM) && ($signed(cos_o) >= -LIM));

endmodule

bind qws_synth qws_synth_chk #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .inc_i (inc_i),
    .acc_q (acc_q),
    .ph_q  (ph_q),
    .sin_o (sin_o),
    .cos_o (cos_o)
);

// File: tb/qws_synth_test.sv
module qws_synth_test;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        en_i  = 1'b0;
    logic [23:0] inc_i = '0;
    logic [11:0] ofs_i = '0;
    logic [11:0] sin_o;
    logic [11:0] cos_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural model state
    longint m_acc = 0;
    int     m_ph  = 0;
    int     m_sin = 0;
    int     m_cos = 0;
    int     m_sph = -1;

    localparam longint MASK = (longint'(1) << 24) - 1;

    always #4 clk_i = ~clk_i;

    qws_synth uut (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .inc_i (inc_i),
        .ofs_i (ofs_i),
        .sin_o (sin_o),
        .cos_o (cos_o)
    );

    // amplitude from the stated segment rule (R4, R5, R6)
    function automatic int ref_amp(input int p);
        int q, r, s, u, base, a, b, mag;
        int bases [8] = '{0, 200, 391, 568, 723, 851, 945, 1003};
        int sha   [8] = '{0, 0, 0, 0, 1, 1, 2, 3};
        int shb   [8] = '{1, 1, 2, 3, 1, 2, 3, 5};
        q = p / 1024;
        r = p % 1024;
        if (q % 2 == 1) r = 1023 - r;
        s = r / 128;
        u = r % 128;
        base = bases[s];
        a = sha[s];
        b = shb[s];
        mag = base + (u >> a) + (u >> b);
        return (q >= 2) ? -mag : mag;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit r, input bit e, input longint inc,
                       input int ofs, input string tag);
        real ideal;
        int  dev;
        rst_i = r;
        en_i  = e;
        inc_i = 24'(inc);
        ofs_i = 12'(ofs);
        if (r) begin
            m_acc = 0; m_ph = 0; m_sin = 0; m_cos = 0; m_sph = -1;
        end else begin
            m_sin = ref_amp(m_ph);
            m_cos = ref_amp((m_ph + 1024) % 4096);
            m_sph = m_ph;
            m_ph  = int'(((m_acc >> 12) + longint'(ofs)) % 4096);
            if (e) m_acc = (m_acc + inc) & MASK;
        end
        @(posedge clk_i);
        @(negedge clk_i);
        chk({tag, " sin"}, int'($signed(sin_o)), m_sin);
        chk({tag, " cos"}, int'($signed(cos_o)), m_cos);
        if (m_sph >= 0) begin
            // R10: closeness to the true sine
            ideal = 1023.0 * $sin(2.0 * 3.14159265358979 * real'(m_sph) / 4096.0);
            dev = int'($signed(sin_o)) - int'($rtoi(ideal + ((ideal >= 0.0) ? 0.5 : -0.5)));
            n_chk++;
            if (dev > 24 || dev < -24) begin
                n_fail++;
                $display("FAIL R10: actual %0d expected %0.1f within 24",
                         int'($signed(sin_o)), ideal);
            end
        end
    endtask

    task automatic spot(input int ofs, input int exp_sin, input int exp_cos,
                        input string tag);
        cyc(1'b1, 1'b0, 0, 0, "R1");
        cyc(1'b0, 1'b1, 0, ofs, tag);
        cyc(1'b0, 1'b1, 0, ofs, tag);
        chk({tag, " spot sin"}, int'($signed(sin_o)), exp_sin);
        chk({tag, " spot cos"}, int'($signed(cos_o)), exp_cos);
    endtask

    initial begin
        @(negedge clk_i);
        // R1: reset state and quiet start
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 0, 0, "R1");
        chk("R1 reset sin", int'($signed(sin_o)), 0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 0, 0, "R1");

        // R3: two-stage latency seen through the offset path
        cyc(1'b1, 1'b0, 0, 0, "R1");
        cyc(1'b0, 1'b1, 0, 1024, "R3");
        chk("R3 first edge", int'($signed(sin_o)), 0);
        cyc(1'b0, 1'b1, 0, 1024, "R3");
        chk("R3 second edge", int'($signed(sin_o)), 1021);

        // R4/R6/R7 fixed points
        spot(512,  723,   710,   "R4");
        spot(1536, 710,   -723,  "R4");
        spot(2560, -723,  -710,  "R6");
        spot(3072, -1021, 0,     "R6");
        spot(1024, 1021,  0,     "R7");

        // R5: full circle sweep, one phase step per clock
        cyc(1'b1, 1'b0, 0, 0, "R1");
        for (int i = 0; i < 4200; i++) cyc(1'b0, 1'b1, 4096, 0, "R5");

        // R9/R8: hops with offset changes landing on the same edge
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 40 + k; i++)
                cyc(1'b0, 1'b1, 37 + longint'(k) * 64'h0F1357,
                    (k % 2 == 1) ? 4095 - k : 0, "R9");
        end
        // R2: near full-scale increments wrap almost every cycle
        for (int i = 0; i < 50; i++) cyc(1'b0, 1'b1, 24'hFFF123 - i, i * 81, "R2");
        // R2: hold with enable low while inputs move
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 24'h3A5C7 + i, 300, "R2");

        // R8: offsets around the wrap point
        for (int i = 0; i < 60; i++)
            cyc(1'b0, 1'b1, 12345, (i % 3 == 0) ? 4095 : ((i % 3 == 1) ? 2048 : 4001), "R8");

        // R1: reset in mid-run
        cyc(1'b1, 1'b1, 99999, 7, "R1");
        chk("R1 midrun sin", int'($signed(sin_o)), 0);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 99999, 7, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule